// File: doc/BRIEF.md
# Two-Group Phase-Aligned Clock Divider

This block takes one fast oscillator clock and produces two banks of derived clocks: bank A with four outputs and bank B with five. Each bank picks its own divide ratio from a small set of even ratios, and each bank has its own enable pattern. The enable bits stand in for the tri-state control of the output drivers. A separate output flags the one enable combination that is not allowed, so that the status pins elsewhere can be pulled low.

Two reset sources are combined: an active-low power-on reset and an active-low master reset. Either one asserts asynchronously and forces every clock output low at once, even for a pulse shorter than one fast-clock period. The release goes through a two-stage synchroniser, so every divider leaves reset on the same fast-clock edge and all nine outputs rise together. Software that changes a ratio while running must pulse the master reset to bring the banks back into phase. A bypass select routes an external clock to all outputs with no division, which is useful for test.

Top module: `clkdiv_two_group`

## Requirements
- R1: The bank A ratio code selects the divide ratio 00 = /40, 01 = /20, 10 = /16, 11 = /8. The output stays high for half the ratio in fast-clock cycles, then low for the other half.
- R2: The bank B ratio code selects the divide ratio 00 = /40, 01 = /20, 10 = /10, 11 = /8. The half-period rule of R1 applies.
- R3: Every divided output has a 50% duty cycle: its high time and its low time are equal, each lasting ratio/2 fast-clock cycles.
- R4: The bank A enable code drives a_oe[3:0]: 00 or 11 enables all four outputs, 01 enables only outputs 0 and 1, and 10 disables all four.
- R5: The bank B enable code drives b_oe[4:0]: 00 or 11 enables all five outputs, 01 enables outputs 0 to 2, and 10 enables only output 0.
- R6: While por_n or mrst_n is low, every bit of a_clk and b_clk is 0. This includes bypass mode and master-reset pulses shorter than one clock period, and the outputs go low without waiting for a clock edge.
- R7: Release from reset goes through two synchroniser stages. Take the edge at which both resets are first seen high as edge 0. Every output of both banks is still low after edge 1, and all of them go high together on edge 2.
- R8: When byp_sel is 1 and no reset is active, every output bit equals byp_clk, with no division.
- R9: ind_force_low is 1 exactly when both enable codes are 10, and 0 for every other combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast oscillator clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| a_ratio | input | 2 | Bank A ratio code |
| a_en_code | input | 2 | Bank A enable code |
| b_ratio | input | 2 | Bank B ratio code |
| b_en_code | input | 2 | Bank B enable code |
| byp_sel | input | 1 | 1 selects the bypass clock for all outputs |
| byp_clk | input | 1 | Bypass clock |
| a_clk | output | 4 | Bank A clock values |
| a_oe | output | 4 | Bank A output enables (0 = high impedance) |
| b_clk | output | 5 | Bank B clock values |
| b_oe | output | 5 | Bank B output enables (0 = high impedance) |
| ind_force_low | output | 1 | Invalid enable combination; status indicators held low |

## Verification
The bench samples on the falling edge, and counts releases from the first rising edge after the master reset goes high. The output must still be low after that edge and the next one, and high after the edge after that. From then on, each bank must change level exactly half its ratio later, and change again after the same count. The enable bits, the bypass path and the invalid-combination flag are combinational, so they are checked one nanosecond after the inputs change. The forced-low state under reset is checked within the same clock period as the reset, including a sub-period pulse that falls between two edges.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int CNT_W = 5;

    typedef enum logic [1:0] {
        EN_FULL = 2'b00,
        EN_PART = 2'b01,
        EN_MIN  = 2'b10,
        EN_RSV  = 2'b11
    } en_code_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lvl;
    } div_st_t;

    // half period in fast cycles; code 2 differs per bank
    function automatic logic [CNT_W-1:0] half_of(input logic [1:0] code,
                                                 input logic [CNT_W-1:0] alt);
        case (code)
            2'd0:    half_of = CNT_W'(20);
            2'd1:    half_of = CNT_W'(10);
            2'd2:    half_of = alt;
            default: half_of = CNT_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_ok
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign rst_ok = sh_q[STAGES-1];
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int N_OUT    = 4,
    parameter int N_PART   = 2,
    parameter int N_MIN    = 0,
    parameter int HALF_ALT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       ratio,
    input  logic [1:0]       en_code,
    input  logic             byp_sel,
    input  logic             byp_clk,
    output logic [N_OUT-1:0] clk_o,
    output logic [N_OUT-1:0] oe_o
);
    localparam logic [CNT_W-1:0] ALT = CNT_W'(HALF_ALT);

    div_st_t          st_d, st_q;
    logic [CNT_W-1:0] half_m1;
    logic             level;
    int               n_on;

    always_comb begin
        half_m1 = half_of(ratio, ALT) - CNT_W'(1);
        st_d    = st_q;
        if (st_q.cnt >= half_m1) begin
            st_d.cnt = '0;
            st_d.lvl = ~st_q.lvl;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    // counter parks at all-ones so the first released edge toggles high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '1, lvl: 1'b0};
        else        st_q <= st_d;
    end

    always_comb begin
        if (!rst_n)       level = 1'b0;
        else if (byp_sel) level = byp_clk;
        else              level = st_q.lvl;
    end

    always_comb begin
        case (en_code)
            EN_PART: n_on = N_PART;
            EN_MIN:  n_on = N_MIN;
            default: n_on = N_OUT;
        endcase
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        assign clk_o[i] = level;
        assign oe_o[i]  = (i < n_on);
    end
endmodule

// File: rtl/clkdiv_two_group.sv
module clkdiv_two_group
    import clkdiv_pkg::*;
#(
    parameter int A_OUTS = 4,
    parameter int B_OUTS = 5
) (
    input  logic              clk_fast,
    input  logic              por_n,
    input  logic              mrst_n,
    input  logic [1:0]        a_ratio,
    input  logic [1:0]        a_en_code,
    input  logic [1:0]        b_ratio,
    input  logic [1:0]        b_en_code,
    input  logic              byp_sel,
    input  logic              byp_clk,
    output logic [A_OUTS-1:0] a_clk,
    output logic [A_OUTS-1:0] a_oe,
    output logic [B_OUTS-1:0] b_clk,
    output logic [B_OUTS-1:0] b_oe,
    output logic              ind_force_low
);
    logic arst_n;
    logic rst_ok;

    assign arst_n = por_n & mrst_n;

    clkdiv_rst_sync #(.STAGES(2)) u_sync (
        .clk    (clk_fast),
        .arst_n (arst_n),
        .rst_ok (rst_ok)
    );

    clkdiv_bank #(.N_OUT(A_OUTS), .N_PART(2), .N_MIN(0), .HALF_ALT(8)) u_bank_a (
        .clk     (clk_fast),
        .rst_n   (rst_ok),
        .ratio   (a_ratio),
        .en_code (a_en_code),
        .byp_sel (byp_sel),
        .byp_clk (byp_clk),
        .clk_o   (a_clk),
        .oe_o    (a_oe)
    );

    clkdiv_bank #(.N_OUT(B_OUTS), .N_PART(3), .N_MIN(1), .HALF_ALT(5)) u_bank_b (
        .clk     (clk_fast),
        .rst_n   (rst_ok),
        .ratio   (b_ratio),
        .en_code (b_en_code),
        .byp_sel (byp_sel),
        .byp_clk (byp_clk),
        .clk_o   (b_clk),
        .oe_o    (b_oe)
    );

    assign ind_force_low = (a_en_code == EN_MIN) && (b_en_code == EN_MIN);
endmodule

// File: rtl/clkdiv_two_group_chk.sv
module clkdiv_two_group_chk (
    input logic       clk,
    input logic       por_n,
    input logic       mrst_n,
    input logic       rst_ok,
    input logic       byp_sel,
    input logic       byp_clk,
    input logic [3:0] a_clk,
    input logic [4:0] b_clk,
    input logic [3:0] a_oe,
    input logic [4:0] b_oe,
    input logic       ind_force_low
);
    // R6: master reset forces all outputs low
    a_r6_reset_low: assert property (@(posedge clk) disable iff (!por_n)
        !mrst_n |-> (a_clk == 4'h0 && b_clk == 5'h00));

    // R7: first edge after synchronised release raises both banks
    a_r7_first_rise: assert property (@(posedge clk) disable iff (!rst_ok)
        ($rose(rst_ok) && !byp_sel) |=> (byp_sel || (a_clk == 4'hF && b_clk == 5'h1F)));

    // R3: a divided high phase lasts more than one cycle
    a_r3_high_holds: assert property (@(posedge clk) disable iff (!rst_ok)
        ($rose(a_clk[0]) && !byp_sel && $past(!byp_sel)) |=> (byp_sel || a_clk[0]));

    // R8: bypass passes the bypass clock
    a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_ok)
        byp_sel |-> (a_clk[0] == byp_clk && b_clk[0] == byp_clk));

    // R9: invalid combination goes with bank A off and bank B reduced to output 0
    a_r9_flag_pattern: assert property (@(posedge clk) disable iff (!por_n)
        ind_force_low |-> (a_oe == 4'h0 && b_oe == 5'h01));
endmodule

bind clkdiv_two_group clkdiv_two_group_chk u_chk (
    .clk           (clk_fast),
    .por_n         (por_n),
    .mrst_n        (mrst_n),
    .rst_ok        (rst_ok),
    .byp_sel       (byp_sel),
    .byp_clk       (byp_clk),
    .a_clk         (a_clk),
    .b_clk         (b_clk),
    .a_oe          (a_oe),
    .b_oe          (b_oe),
    .ind_force_low (ind_force_low)
);

// File: tb/clkdiv_two_group_tb.sv
`timescale 1ns/100ps
module clkdiv_two_group_tb;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       mrst_n = 1'b1;
    logic [1:0] a_ratio = 2'b00, a_en_code = 2'b00;
    logic [1:0] b_ratio = 2'b00, b_en_code = 2'b00;
    logic       byp_sel = 1'b0, byp_clk = 1'b0;
    logic [3:0] a_clk, a_oe;
    logic [4:0] b_clk, b_oe;
    logic       ind_force_low;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [3:0] sa [48];
    logic [4:0] sb [48];

    typedef struct packed {
        logic [1:0] ar;
        logic [1:0] br;
        logic [1:0] ae;
        logic [1:0] be;
        logic [7:0] ah;
        logic [7:0] bh;
        logic [3:0] aoe;
        logic [4:0] boe;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{2'b00, 2'b00, 2'b00, 2'b00, 8'd20, 8'd20, 4'hF, 5'h1F},
        '{2'b01, 2'b10, 2'b10, 2'b01, 8'd10, 8'd5,  4'h0, 5'h07},
        '{2'b10, 2'b11, 2'b01, 2'b10, 8'd8,  8'd4,  4'h3, 5'h01},
        '{2'b11, 2'b01, 2'b11, 2'b11, 8'd4,  8'd10, 4'hF, 5'h1F}
    };

    always #2 clk = ~clk;

    clkdiv_two_group u_dut (
        .clk_fast      (clk),
        .por_n         (por_n),
        .mrst_n        (mrst_n),
        .a_ratio       (a_ratio),
        .a_en_code     (a_en_code),
        .b_ratio       (b_ratio),
        .b_en_code     (b_en_code),
        .byp_sel       (byp_sel),
        .byp_clk       (byp_clk),
        .a_clk         (a_clk),
        .a_oe          (a_oe),
        .b_clk         (b_clk),
        .b_oe          (b_oe),
        .ind_force_low (ind_force_low)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // release master reset at a falling edge and record the following samples
    task automatic release_and_record();
        mrst_n = 1'b1;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            sa[i] = a_clk;
            sb[i] = b_clk;
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R6: power-on reset holds outputs low
        repeat (3) @(negedge clk);
        chk("R6 por a_clk", a_clk, 0);
        chk("R6 por b_clk", b_clk, 0);
        byp_sel = 1'b1; byp_clk = 1'b1;
        #1;
        chk("R6 por bypass a_clk", a_clk, 0);
        byp_sel = 1'b0; byp_clk = 1'b0;
        @(negedge clk);
        por_n = 1'b1;

        for (int v = 0; v < 4; v++) begin
            int ha, hb;
            @(negedge clk);
            mrst_n = 1'b0;
            a_ratio = VEC[v].ar; b_ratio = VEC[v].br;
            a_en_code = VEC[v].ae; b_en_code = VEC[v].be;
            repeat (3) @(negedge clk);
            chk("R6 mrst a_clk", a_clk, 0);
            chk("R6 mrst b_clk", b_clk, 0);
            chk("R4 a_oe", a_oe, VEC[v].aoe);
            chk("R5 b_oe", b_oe, VEC[v].boe);
            release_and_record();
            ha = int'(VEC[v].ah);
            hb = int'(VEC[v].bh);
            chk("R7 low after edge 1 a", sa[1], 0);
            chk("R7 low after edge 1 b", sb[1], 0);
            chk("R7 aligned rise a", sa[2], 4'hF);
            chk("R7 aligned rise b", sb[2], 5'h1F);
            chk("R1 a high end", sa[1+ha], 4'hF);
            chk("R1 a falls", sa[2+ha], 4'h0);
            chk("R3 a low end", sa[1+2*ha], 4'h0);
            chk("R3 a rises", sa[2+2*ha], 4'hF);
            chk("R2 b high end", sb[1+hb], 5'h1F);
            chk("R2 b falls", sb[2+hb], 5'h00);
            chk("R3 b low end", sb[1+2*hb], 5'h00);
            chk("R3 b rises", sb[2+2*hb], 5'h1F);
            chk("R9 flag clear", ind_force_low, 0);
        end

        // R9: invalid combination
        a_en_code = 2'b10; b_en_code = 2'b10;
        #1;
        chk("R9 flag set", ind_force_low, 1);
        chk("R4 a_oe in invalid mode", a_oe, 4'h0);
        chk("R5 b_oe in invalid mode", b_oe, 5'h01);
        a_en_code = 2'b00;
        #1;
        chk("R9 flag clear again", ind_force_low, 0);

        // R6: sub-period master reset pulse, then R7 restart
        @(negedge clk);
        a_ratio = 2'b11; b_ratio = 2'b11; b_en_code = 2'b00;
        repeat (3) @(negedge clk);
        #0.5 mrst_n = 1'b0;
        #0.5;
        chk("R6 short pulse a_clk", a_clk, 0);
        chk("R6 short pulse b_clk", b_clk, 0);
        #0.5;
        release_and_record();
        chk("R7 short pulse low", sa[1], 0);
        chk("R7 short pulse rise a", sa[2], 4'hF);
        chk("R7 short pulse rise b", sb[2], 5'h1F);

        // R8: bypass passes the clock through
        @(negedge clk);
        byp_sel = 1'b1; byp_clk = 1'b1;
        #1;
        chk("R8 bypass high a", a_clk, 4'hF);
        chk("R8 bypass high b", b_clk, 5'h1F);
        @(negedge clk);
        byp_clk = 1'b0;
        #1;
        chk("R8 bypass low a", a_clk, 4'h0);
        chk("R8 bypass low b", b_clk, 5'h00);
        @(negedge clk);
        byp_clk = 1'b1;
        mrst_n = 1'b0;
        #1;
        chk("R6 bypass under reset", b_clk, 5'h00);
        @(negedge clk);
        byp_sel = 1'b0; byp_clk = 1'b0;
        mrst_n = 1'b1;
        repeat (4) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule